// File: doc/BRIEF.md
# Scaler phase increment calculator

This block prepares the per-frame geometry a polyphase video scaler needs. Given source and destination luma resolutions, a source and destination sampling format and a chroma siting code, it derives the chroma plane sizes and four phase increments with 13 fractional bits: luma vertical, luma horizontal, chroma vertical and chroma horizontal. It also derives the chroma start phases from the siting code and packs four resolution words in the layout the scaler's line engine decodes.

One pulse on `start` captures every input. A single restoring divider, which produces one quotient bit per cycle, computes the four quotients in a fixed order. When the last quotient is ready, every result is registered together and `valid` pulses for one cycle. If any divisor would be zero, `err` pulses instead, no division runs, and the result outputs keep their previous values.

The controller is a state machine with these states:
- ST_IDLE waits for `start`. On `start` it captures the inputs and moves to ST_CHECK.
- ST_CHECK moves to ST_FAULT when a divisor is zero, and to ST_LAUNCH otherwise.
- ST_LAUNCH starts the divider on the selected pair and moves to ST_WAIT.
- ST_WAIT stores the quotient when the divider finishes. It then moves back to ST_LAUNCH for the next pair, or to ST_DONE after the fourth pair.
- ST_DONE (valid) returns to ST_IDLE.
- ST_FAULT (err) returns to ST_IDLE.

Top module: `scl_phase_calc`

## Requirements
- R1: Each luma increment equals floor(((src << 13) + floor(dst/2)) / dst). The vertical increment uses the heights and the horizontal increment uses the widths.
- R2: Chroma increments use the same formula on chroma sizes. Format codes are 0 = 4:2:0, 1 = 4:2:2 and 2 = 4:4:4/RGB; code 3 is treated as 4:4:4. A 4:2:0 source halves both chroma source width and height (floor). A 4:2:2 source halves only the chroma source width. A 4:2:2 destination halves the chroma destination width.
- R3: With a 4:2:0 source, the chroma vertical start is -2048 for siting codes 0 and 1, -4096 for codes 4 and 5, and 0 for all other codes.
- R4: With a 4:2:0 source, the chroma horizontal start is -2048 for siting codes 1, 3 and 5, and 0 for all other codes. The luma start phases are implicitly zero.
- R5: The start outputs are 19-bit two's complement values, so -2048 is 0x7F800 and -4096 is 0x7F000. For any source that is not 4:2:0, both starts are 0 whatever the siting.
- R6: A resolution word holds (width-1) in bits 11:0, (height-1) in bits 27:16, and zeros elsewhere. There are four words: source luma, source chroma, destination luma and destination chroma. Each uses the chroma sizes of R2.
- R7: When a 4:4:4 source goes to a 4:2:2 destination, the source luma and source chroma heights are each reduced by one before packing. The increments still use the unreduced heights.
- R8: If the destination width or height, or the derived chroma destination width or height, is zero, `err` pulses for one cycle. In that case `valid` does not pulse and all result outputs keep their previous values.
- R9: `start` is accepted only when `busy` is low. `busy` is high from the cycle after an accepted `start` through the `valid` or `err` cycle, and a `start` seen during that time is ignored.
- R10: `valid` is a single-cycle pulse. All results are updated together with it and hold until the next successful computation. After reset, `busy`, `valid` and `err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Capture inputs and begin computing |
| src_w | input | RES_W | Source luma width |
| src_h | input | RES_W | Source luma height |
| dst_w | input | RES_W | Destination luma width |
| dst_h | input | RES_W | Destination luma height |
| src_fmt | input | 2 | Source format code |
| dst_fmt | input | 2 | Destination format code |
| siting | input | 3 | Chroma siting code |
| busy | output | 1 | Computation in progress |
| valid | output | 1 | One-cycle pulse: results updated |
| err | output | 1 | One-cycle pulse: zero divisor, no results |
| luma_vinc | output | RES_W+13 | Luma vertical increment |
| luma_hinc | output | RES_W+13 | Luma horizontal increment |
| chroma_vinc | output | RES_W+13 | Chroma vertical increment |
| chroma_hinc | output | RES_W+13 | Chroma horizontal increment |
| chroma_vstart | output | 19 | Chroma vertical start phase |
| chroma_hstart | output | 19 | Chroma horizontal start phase |
| src_luma_word | output | 32 | Packed source luma resolution |
| src_chroma_word | output | 32 | Packed source chroma resolution |
| dst_luma_word | output | 32 | Packed destination luma resolution |
| dst_chroma_word | output | 32 | Packed destination chroma resolution |

## Verification
The divider's exactness check assumes the divisor is never zero when a division starts, because ST_CHECK filters out every zero divisor before ST_LAUNCH. The remaining checks assume the inputs are captured only in ST_IDLE, so the captured sizes stay fixed throughout a run. The stimulus keeps every resolution below 4096, so no field is truncated. It raises `start` only for one cycle per operation, except in the deliberate test of a `start` during a busy run. It includes zero and one-pixel destinations to reach the fault path.

// File: rtl/scl_pkg.sv
package scl_pkg;
    localparam int FRAC_BITS = 13;
    localparam int FIELD_W   = 12;
    localparam int START_W   = 19;
    localparam int WORD_W    = 32;
    localparam int HGT_LSB   = 16;

    typedef enum logic [1:0] {
        FMT_420  = 2'd0,
        FMT_422  = 2'd1,
        FMT_444  = 2'd2,
        FMT_RSVD = 2'd3
    } fmt_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CHECK,
        ST_LAUNCH,
        ST_WAIT,
        ST_DONE,
        ST_FAULT
    } state_e;

    typedef enum logic [1:0] {
        DIV_LUMA_V = 2'd0,
        DIV_LUMA_H = 2'd1,
        DIV_CHR_V  = 2'd2,
        DIV_CHR_H  = 2'd3
    } div_sel_e;
endpackage

// File: rtl/scl_seq_divider.sv
module scl_seq_divider #(
    parameter int NUM_W = 25,
    parameter int DEN_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [NUM_W-1:0] num,
    input  logic [DEN_W-1:0] den,
    output logic             done,
    output logic [NUM_W-1:0] quo
);
    localparam int CNT_W = $clog2(NUM_W + 1);

    logic [NUM_W-1:0] q_r;
    logic [NUM_W-1:0] num_r;
    logic [DEN_W-1:0] rem_r;
    logic [DEN_W-1:0] den_r;
    logic [CNT_W-1:0] cnt_r;
    logic             run_r;
    logic             done_r;
    logic [DEN_W:0]   shifted;
    logic [DEN_W:0]   diff;
    logic             fits;

    assign shifted = {rem_r, q_r[NUM_W-1]};
    assign fits    = shifted >= {1'b0, den_r};
    assign diff    = shifted - {1'b0, den_r};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_r    <= '0;
            num_r  <= '0;
            rem_r  <= '0;
            den_r  <= '0;
            cnt_r  <= '0;
            run_r  <= 1'b0;
            done_r <= 1'b0;
        end else begin
            done_r <= 1'b0;
            if (start && !run_r) begin
                q_r   <= num;
                num_r <= num;
                rem_r <= '0;
                den_r <= den;
                cnt_r <= CNT_W'(NUM_W);
                run_r <= 1'b1;
            end else if (run_r) begin
                q_r   <= {q_r[NUM_W-2:0], fits};
                rem_r <= fits ? diff[DEN_W-1:0] : shifted[DEN_W-1:0];
                cnt_r <= cnt_r - 1'b1;
                if (cnt_r == CNT_W'(1)) begin
                    run_r  <= 1'b0;
                    done_r <= 1'b1;
                end
            end
        end
    end

    assign done = done_r;
    assign quo  = q_r;

    AST_DIV_EXACT: assert property (@(posedge clk) disable iff (!rst_n)
        done_r |-> ((64'(q_r) * 64'(den_r) + 64'(rem_r)) == 64'(num_r)) && (rem_r < den_r)); // R1
endmodule

// File: rtl/scl_chroma_geom.sv
module scl_chroma_geom
    import scl_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic [RES_W-1:0]   src_w,
    input  logic [RES_W-1:0]   src_h,
    input  logic [RES_W-1:0]   dst_w,
    input  logic [RES_W-1:0]   dst_h,
    input  fmt_e               src_fmt,
    input  fmt_e               dst_fmt,
    input  logic [2:0]         siting,
    output logic [RES_W-1:0]   c_src_w,
    output logic [RES_W-1:0]   c_src_h,
    output logic [RES_W-1:0]   c_dst_w,
    output logic [RES_W-1:0]   c_dst_h,
    output logic [START_W-1:0] vstart,
    output logic [START_W-1:0] hstart,
    output logic [WORD_W-1:0]  word_sl,
    output logic [WORD_W-1:0]  word_sc,
    output logic [WORD_W-1:0]  word_dl,
    output logic [WORD_W-1:0]  word_dc
);
    localparam logic [START_W-1:0] QUARTER = START_W'(1 << (FRAC_BITS - 2));
    localparam logic [START_W-1:0] HALF    = START_W'(1 << (FRAC_BITS - 1));

    logic             trim;
    logic [RES_W-1:0] sl_h_adj;
    logic [RES_W-1:0] sc_h_adj;

    function automatic logic [WORD_W-1:0] pack_res(input logic [RES_W-1:0] w,
                                                  input logic [RES_W-1:0] h);
        logic [WORD_W-1:0] r;
        logic [RES_W-1:0]  wm;
        logic [RES_W-1:0]  hm;
        wm = w - 1'b1;
        hm = h - 1'b1;
        r  = '0;
        r[FIELD_W-1:0]               = FIELD_W'(wm);
        r[HGT_LSB+FIELD_W-1:HGT_LSB] = FIELD_W'(hm);
        return r;
    endfunction

    always_comb begin
        c_src_w = src_w;
        c_src_h = src_h;
        if (src_fmt == FMT_420) begin
            c_src_w = src_w >> 1;
            c_src_h = src_h >> 1;
        end else if (src_fmt == FMT_422) begin
            c_src_w = src_w >> 1;
        end
        c_dst_w = (dst_fmt == FMT_422) ? (dst_w >> 1) : dst_w;
        c_dst_h = dst_h;
    end

    always_comb begin
        vstart = '0;
        hstart = '0;
        if (src_fmt == FMT_420) begin
            case (siting)
                3'd0, 3'd1: vstart = -QUARTER;
                3'd4, 3'd5: vstart = -HALF;
                default:    vstart = '0;
            endcase
            case (siting)
                3'd1, 3'd3, 3'd5: hstart = -QUARTER;
                default:          hstart = '0;
            endcase
        end
    end

    assign trim     = (src_fmt != FMT_420) && (src_fmt != FMT_422) && (dst_fmt == FMT_422);
    assign sl_h_adj = trim ? src_h - 1'b1 : src_h;
    assign sc_h_adj = trim ? c_src_h - 1'b1 : c_src_h;

    assign word_sl = pack_res(src_w, sl_h_adj);
    assign word_sc = pack_res(c_src_w, sc_h_adj);
    assign word_dl = pack_res(dst_w, dst_h);
    assign word_dc = pack_res(c_dst_w, c_dst_h);
endmodule

// File: rtl/scl_phase_calc.sv
module scl_phase_calc
    import scl_pkg::*;
#(
    parameter int RES_W = 12
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic [RES_W-1:0]           src_w,
    input  logic [RES_W-1:0]           src_h,
    input  logic [RES_W-1:0]           dst_w,
    input  logic [RES_W-1:0]           dst_h,
    input  logic [1:0]                 src_fmt,
    input  logic [1:0]                 dst_fmt,
    input  logic [2:0]                 siting,
    output logic                       busy,
    output logic                       valid,
    output logic                       err,
    output logic [RES_W+FRAC_BITS-1:0] luma_vinc,
    output logic [RES_W+FRAC_BITS-1:0] luma_hinc,
    output logic [RES_W+FRAC_BITS-1:0] chroma_vinc,
    output logic [RES_W+FRAC_BITS-1:0] chroma_hinc,
    output logic [START_W-1:0]         chroma_vstart,
    output logic [START_W-1:0]         chroma_hstart,
    output logic [WORD_W-1:0]          src_luma_word,
    output logic [WORD_W-1:0]          src_chroma_word,
    output logic [WORD_W-1:0]          dst_luma_word,
    output logic [WORD_W-1:0]          dst_chroma_word
);
    localparam int NUM_W = RES_W + FRAC_BITS;

    state_e           state_q, state_d;
    div_sel_e         sel_q;
    logic [RES_W-1:0] src_w_q, src_h_q, dst_w_q, dst_h_q;
    fmt_e             src_fmt_q, dst_fmt_q;
    logic [2:0]       siting_q;
    logic [NUM_W-1:0] lv_q, lh_q, cv_q;

    logic [RES_W-1:0]   c_src_w, c_src_h, c_dst_w, c_dst_h;
    logic [START_W-1:0] g_vstart, g_hstart;
    logic [WORD_W-1:0]  g_sl, g_sc, g_dl, g_dc;
    logic [RES_W-1:0]   n_src, n_dst;
    logic [NUM_W-1:0]   div_num, div_quo;
    logic               div_start, div_done, zero_div;

    scl_chroma_geom #(.RES_W(RES_W)) i_geom (
        .src_w(src_w_q), .src_h(src_h_q), .dst_w(dst_w_q), .dst_h(dst_h_q),
        .src_fmt(src_fmt_q), .dst_fmt(dst_fmt_q), .siting(siting_q),
        .c_src_w(c_src_w), .c_src_h(c_src_h), .c_dst_w(c_dst_w), .c_dst_h(c_dst_h),
        .vstart(g_vstart), .hstart(g_hstart),
        .word_sl(g_sl), .word_sc(g_sc), .word_dl(g_dl), .word_dc(g_dc)
    );

    always_comb begin
        case (sel_q)
            DIV_LUMA_V: begin n_src = src_h_q; n_dst = dst_h_q; end
            DIV_LUMA_H: begin n_src = src_w_q; n_dst = dst_w_q; end
            DIV_CHR_V:  begin n_src = c_src_h; n_dst = c_dst_h; end
            default:    begin n_src = c_src_w; n_dst = c_dst_w; end
        endcase
        div_num = {n_src, {FRAC_BITS{1'b0}}} + NUM_W'(n_dst >> 1);
    end

    scl_seq_divider #(.NUM_W(NUM_W), .DEN_W(RES_W)) i_div (
        .clk(clk), .rst_n(rst_n), .start(div_start),
        .num(div_num), .den(n_dst), .done(div_done), .quo(div_quo)
    );

    assign zero_div = (dst_w_q == '0) || (dst_h_q == '0) ||
                      (c_dst_w == '0) || (c_dst_h == '0);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start) state_d = ST_CHECK;
            ST_CHECK:  state_d = zero_div ? ST_FAULT : ST_LAUNCH;
            ST_LAUNCH: state_d = ST_WAIT;
            ST_WAIT:   if (div_done) state_d = (sel_q == DIV_CHR_H) ? ST_DONE : ST_LAUNCH;
            ST_DONE:   state_d = ST_IDLE;
            ST_FAULT:  state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs decoded from state
    always_comb begin
        busy      = (state_q != ST_IDLE);
        valid     = (state_q == ST_DONE);
        err       = (state_q == ST_FAULT);
        div_start = (state_q == ST_LAUNCH);
    end

    // datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= DIV_LUMA_V;
            src_w_q <= '0; src_h_q <= '0; dst_w_q <= '0; dst_h_q <= '0;
            src_fmt_q <= FMT_420; dst_fmt_q <= FMT_420; siting_q <= '0;
            lv_q <= '0; lh_q <= '0; cv_q <= '0;
            luma_vinc <= '0; luma_hinc <= '0; chroma_vinc <= '0; chroma_hinc <= '0;
            chroma_vstart <= '0; chroma_hstart <= '0;
            src_luma_word <= '0; src_chroma_word <= '0;
            dst_luma_word <= '0; dst_chroma_word <= '0;
        end else begin
            if (state_q == ST_IDLE && start) begin
                src_w_q   <= src_w;
                src_h_q   <= src_h;
                dst_w_q   <= dst_w;
                dst_h_q   <= dst_h;
                src_fmt_q <= fmt_e'(src_fmt);
                dst_fmt_q <= fmt_e'(dst_fmt);
                siting_q  <= siting;
            end
            if (state_q == ST_CHECK) sel_q <= DIV_LUMA_V;
            if (state_q == ST_WAIT && div_done) begin
                case (sel_q)
                    DIV_LUMA_V: lv_q <= div_quo;
                    DIV_LUMA_H: lh_q <= div_quo;
                    DIV_CHR_V:  cv_q <= div_quo;
                    default: begin
                        luma_vinc       <= lv_q;
                        luma_hinc       <= lh_q;
                        chroma_vinc     <= cv_q;
                        chroma_hinc     <= div_quo;
                        chroma_vstart   <= g_vstart;
                        chroma_hstart   <= g_hstart;
                        src_luma_word   <= g_sl;
                        src_chroma_word <= g_sc;
                        dst_luma_word   <= g_dl;
                        dst_chroma_word <= g_dc;
                    end
                endcase
                sel_q <= div_sel_e'(sel_q + 2'd1);
            end
        end
    end

    AST_LUMA_ROUNDED: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (64'(luma_vinc) * 64'(dst_h_q) <= (64'(src_h_q) << FRAC_BITS) + 64'(dst_h_q >> 1))
               && ((64'(luma_vinc) + 64'd1) * 64'(dst_h_q) > (64'(src_h_q) << FRAC_BITS) + 64'(dst_h_q >> 1))); // R1
    AST_NON420_NO_OFFSET: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && src_fmt_q != FMT_420) |-> (chroma_vstart == '0 && chroma_hstart == '0)); // R5
    AST_ERR_ZERO_DIVISOR: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (dst_w_q == '0 || dst_h_q == '0 || c_dst_w == '0)); // R8
    AST_FAULT_KEEPS_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ($stable(luma_vinc) && $stable(chroma_hinc) && $stable(src_luma_word))); // R8
    AST_START_IGNORED_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(src_w_q) && $stable(dst_h_q) && $stable(siting_q))); // R9
    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid); // R10
endmodule

// File: tb/test_scl_phase_calc.sv
`timescale 1ns/1ps
module test_scl_phase_calc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [11:0] src_w = '0, src_h = '0, dst_w = '0, dst_h = '0;
    logic [1:0]  src_fmt = '0, dst_fmt = '0;
    logic [2:0]  siting = '0;
    logic        busy, valid, err;
    logic [24:0] luma_vinc, luma_hinc, chroma_vinc, chroma_hinc;
    logic [18:0] chroma_vstart, chroma_hstart;
    logic [31:0] src_luma_word, src_chroma_word, dst_luma_word, dst_chroma_word;

    int checks = 0;
    int errors = 0;
    int g_sw, g_sh, g_dw, g_dh, g_sf, g_df, g_st;

    always #2.5 clk = ~clk;

    scl_phase_calc #(.RES_W(12)) i_scl_phase_calc (
        .clk(clk), .rst_n(rst_n), .start(start),
        .src_w(src_w), .src_h(src_h), .dst_w(dst_w), .dst_h(dst_h),
        .src_fmt(src_fmt), .dst_fmt(dst_fmt), .siting(siting),
        .busy(busy), .valid(valid), .err(err),
        .luma_vinc(luma_vinc), .luma_hinc(luma_hinc),
        .chroma_vinc(chroma_vinc), .chroma_hinc(chroma_hinc),
        .chroma_vstart(chroma_vstart), .chroma_hstart(chroma_hstart),
        .src_luma_word(src_luma_word), .src_chroma_word(src_chroma_word),
        .dst_luma_word(dst_luma_word), .dst_chroma_word(dst_chroma_word)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int inc_of(input int s, input int d);
        return ((s << 13) + (d >> 1)) / d;
    endfunction

    function automatic int word_of(input int w, input int h);
        return (((h - 1) & 'hFFF) << 16) | ((w - 1) & 'hFFF);
    endfunction

    task automatic check_results(input int sw, input int sh, input int dw, input int dh,
                                 input int sf, input int df, input int st);
        int csw, csh, cdw, t, evs, ehs;
        csw  = (sf == 0 || sf == 1) ? sw >> 1 : sw;
        csh  = (sf == 0) ? sh >> 1 : sh;
        cdw  = (df == 1) ? dw >> 1 : dw;
        t    = (sf >= 2 && df == 1) ? 1 : 0;
        evs  = 0;
        ehs  = 0;
        if (sf == 0) begin
            if (st == 0 || st == 1) evs = 'h7F800;
            if (st == 4 || st == 5) evs = 'h7F000;
            if (st == 1 || st == 3 || st == 5) ehs = 'h7F800;
        end
        chk(int'(luma_vinc) == inc_of(sh, dh), "R1", "luma vinc", luma_vinc, inc_of(sh, dh));
        chk(int'(luma_hinc) == inc_of(sw, dw), "R1", "luma hinc", luma_hinc, inc_of(sw, dw));
        chk(int'(chroma_vinc) == inc_of(csh, dh), "R2", "chroma vinc", chroma_vinc, inc_of(csh, dh));
        chk(int'(chroma_hinc) == inc_of(csw, cdw), "R2", "chroma hinc", chroma_hinc, inc_of(csw, cdw));
        chk(int'(chroma_vstart) == evs, (sf == 0) ? "R3" : "R5", "chroma vstart", chroma_vstart, evs);
        chk(int'(chroma_hstart) == ehs, (sf == 0) ? "R4" : "R5", "chroma hstart", chroma_hstart, ehs);
        chk(int'(src_luma_word) == word_of(sw, sh - t), t ? "R7" : "R6", "src luma word",
            src_luma_word, word_of(sw, sh - t));
        chk(int'(src_chroma_word) == word_of(csw, csh - t), t ? "R7" : "R6", "src chroma word",
            src_chroma_word, word_of(csw, csh - t));
        chk(int'(dst_luma_word) == word_of(dw, dh), "R6", "dst luma word", dst_luma_word, word_of(dw, dh));
        chk(int'(dst_chroma_word) == word_of(cdw, dh), "R6", "dst chroma word",
            dst_chroma_word, word_of(cdw, dh));
    endtask

    task automatic run_op(input int sw, input int sh, input int dw, input int dh,
                          input int sf, input int df, input int st,
                          output bit got_v, output bit got_e);
        @(negedge clk);
        src_w = 12'(sw); src_h = 12'(sh); dst_w = 12'(dw); dst_h = 12'(dh);
        src_fmt = 2'(sf); dst_fmt = 2'(df); siting = 3'(st);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        got_v = 1'b0;
        got_e = 1'b0;
        for (int n = 0; n < 2000; n++) begin
            if (valid || err) break;
            @(negedge clk);
        end
        got_v = valid;
        got_e = err;
        if (!got_v && !got_e) chk(1'b0, "R9", "operation timeout", 0, 1);
    endtask

    task automatic good_case(input int sw, input int sh, input int dw, input int dh,
                             input int sf, input int df, input int st);
        bit v, e;
        run_op(sw, sh, dw, dh, sf, df, st, v, e);
        chk(v && !e, "R10", "valid without err", {v, e}, 2);
        check_results(sw, sh, dw, dh, sf, df, st);
        g_sw = sw; g_sh = sh; g_dw = dw; g_dh = dh; g_sf = sf; g_df = df; g_st = st;
    endtask

    task automatic test_reset();
        chk(busy == 1'b0, "R10", "busy after reset", busy, 0);
        chk(valid == 1'b0, "R10", "valid after reset", valid, 0);
        chk(err == 1'b0, "R10", "err after reset", err, 0);
    endtask

    task automatic test_rgb_scaling();
        good_case(1920, 1080, 1280, 720, 2, 2, 0);
        good_case(640, 480, 1920, 1080, 2, 2, 5);
        good_case(7, 3, 5, 9, 2, 2, 1);
    endtask

    task automatic test_420_sitings();
        for (int s = 0; s < 8; s++) good_case(1280, 720, 1920, 1080, 0, 2, s);
    endtask

    task automatic test_422_paths();
        good_case(1920, 1080, 1920, 1080, 1, 2, 1);
        good_case(1024, 768, 800, 600, 1, 1, 0);
        good_case(1281, 721, 999, 555, 0, 2, 3);
    endtask

    task automatic test_444_to_422();
        good_case(1920, 1080, 1280, 720, 2, 1, 0);
        good_case(1280, 720, 1280, 720, 3, 1, 4);
    endtask

    task automatic test_fault(input int dw, input int dh, input int df);
        bit v, e;
        run_op(100, 100, dw, dh, 2, df, 0, v, e);
        chk(e && !v, "R8", "err without valid", {v, e}, 1);
        @(negedge clk);
        chk(!valid && !err && !busy, "R8", "idle after fault", {busy, valid, err}, 0);
        check_results(g_sw, g_sh, g_dw, g_dh, g_sf, g_df, g_st);
    endtask

    task automatic test_busy_ignore();
        @(negedge clk);
        src_w = 12'd1920; src_h = 12'd1080; dst_w = 12'd720; dst_h = 12'd480;
        src_fmt = 2'd0; dst_fmt = 2'd2; siting = 3'd5;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R9", "busy after start", busy, 1);
        repeat (3) @(negedge clk);
        src_w = 12'd100; src_h = 12'd50; dst_w = 12'd0; dst_h = 12'd7;
        src_fmt = 2'd2; siting = 3'd2;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int n = 0; n < 2000; n++) begin
            if (valid || err) break;
            @(negedge clk);
        end
        chk(valid && !err, "R9", "busy start ignored", {valid, err}, 2);
        check_results(1920, 1080, 720, 480, 0, 2, 5);
        g_sw = 1920; g_sh = 1080; g_dw = 720; g_dh = 480; g_sf = 0; g_df = 2; g_st = 5;
        @(negedge clk);
        chk(valid == 1'b0, "R10", "valid single cycle", valid, 0);
        repeat (4) @(negedge clk);
        check_results(g_sw, g_sh, g_dw, g_dh, g_sf, g_df, g_st);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL R9 watchdog expired: actual 0 expected 1");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_rgb_scaling();
        test_420_sitings();
        test_422_paths();
        test_444_to_422();
        test_fault(640, 0, 2);
        test_fault(0, 480, 2);
        test_fault(1, 480, 1);
        test_busy_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule